// File: doc/BRIEF.md
# Supply-Aware Write Strobe Qualifier

This block sits between the raw control pins of a byte-wide nonvolatile memory and its internal write controller. It takes a supply-good indication from an external comparator, the active-low select, output-enable and write strobes, and a system clock. From these it produces a one-cycle write-start pulse, and only when a write is legitimate.

Three guards act together. A power lockout holds writes off while the supply is low. After the supply turns good, the lockout stays in force for a programmable settling count. A pin-state filter refuses a write when output enable is low, or when select or write enable is high. A minimum-width filter ignores any write strobe that does not stay active for a programmable number of clock cycles. All four pins first pass through a reset-able synchronizer of `SYNC_STAGES` flops. All timing below counts rising clock edges after the synchronizer.

Top module: `write_inhibit_guard`

## Requirements
- R1: While the synchronized supply-good input is low, `wrStart` stays low in the following cycle, whatever the strobes do.
- R2: After reset, or after a supply drop, `wrStart` can rise only once the synchronized supply-good input has been high on `PWR_DELAY_CYC + 1` consecutive edges. With the strobes already active and supply rising, the first pulse shows after `SYNC_STAGES + PWR_DELAY_CYC + GLITCH_CYC` edges, counted from the first edge that samples supply high.
- R3: Output enable low (`oeN` = 0) inhibits a write start. A write strobe held through an output-enable-low period starts a write only once `oeN` returns high and stays high for the filter width.
- R4: The write strobe is active only when `csN` = 0 and `weN` = 0 together. Either one high inhibits a start, and whichever of the two falls last begins the qualification.
- R5: A write strobe active for fewer than `GLITCH_CYC` consecutive synchronized cycles produces no pulse. One active for `GLITCH_CYC` or more produces a pulse.
- R6: `wrStart` is high for exactly one cycle for each qualified strobe. A further pulse needs the strobe to go inactive first.
- R7: A supply drop of even one cycle during the settling count restarts the full settling count.
- R8: During and right after reset, `wrStart` is low, and the full settling count applies even when supply is already good.
- R9: With the guard armed and the strobe becoming active at the pins, `wrStart` is high after `SYNC_STAGES + GLITCH_CYC` edges, counted from the first edge that samples the active strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Supply-good from the external comparator, high when supply is above threshold |
| csN | input | 1 | Active-low chip select |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| wrStart | output | 1 | One-cycle qualified write-start pulse |

## Verification
On every cycle, the assertions check three things against the synchronized pins: that a low supply, a low output enable, or an inactive select or write enable is followed by no pulse; that each pulse is preceded by a full settling run and a full filter-width run; and that pulses never last two cycles. Some behaviours only the bench scenarios can show. These are the exact latencies from reset, from a supply restart and from a strobe fall; the restart of the settling count after a one-cycle dip; the release of a held strobe by output enable or by a late select; and the pass/reject boundary at exactly `GLITCH_CYC - 1` and `GLITCH_CYC` cycles. The bench shows them by counting edges and pulses at the output, and it compares every cycle of random strobe traffic with a cycle model built from the requirements.

// File: rtl/write_inhibit_guard_pkg.sv
package write_inhibit_guard_pkg;

  // Synchronized view of the input pins.
  typedef struct packed {
    logic weN;
    logic oeN;
    logic csN;
    logic ok;
  } syncPins_t;

  // Strobes from the control FSM to the datapath counters.
  typedef struct packed {
    logic pwrClr;
    logic pwrInc;
    logic widClr;
    logic widInc;
  } guardCtl_t;

  typedef enum logic [2:0] {
    ST_LOCKED = 3'd0,
    ST_IDLE   = 3'd1,
    ST_FILTER = 3'd2,
    ST_FIRE   = 3'd3,
    ST_HOLD   = 3'd4
  } guardState_e;

endpackage

// File: rtl/write_inhibit_guard_datapath.sv
module write_inhibit_guard_datapath
  import write_inhibit_guard_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int PWR_DELAY_CYC = 250000,
  parameter int GLITCH_CYC    = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyOk,
  input  logic      csN,
  input  logic      oeN,
  input  logic      weN,
  input  guardCtl_t ctl,
  output syncPins_t syncPins,
  output logic      pwrLast,
  output logic      widLast
);

  localparam int PW = (PWR_DELAY_CYC < 2) ? 1 : $clog2(PWR_DELAY_CYC);
  localparam int GW = (GLITCH_CYC < 2) ? 1 : $clog2(GLITCH_CYC);
  localparam logic [PW-1:0] PWR_LAST = PW'(PWR_DELAY_CYC - 1);
  localparam logic [GW-1:0] WID_LAST = GW'(GLITCH_CYC - 1);
  // Reset view: supply low, every strobe inactive.
  localparam syncPins_t RST_PINS = '{weN: 1'b1, oeN: 1'b1, csN: 1'b1, ok: 1'b0};

  syncPins_t pinNow;
  assign pinNow = '{weN: weN, oeN: oeN, csN: csN, ok: supplyOk};

  // Synchronizer chain, one register block per stage.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    syncPins_t q;
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= RST_PINS;
        else       q <= pinNow;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= RST_PINS;
        else       q <= gSync[g-1].q;
      end
    end
  end

  assign syncPins = gSync[SYNC_STAGES-1].q;

  // Power-on settling counter.
  logic [PW-1:0] pwrCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pwrCnt <= '0;
    else if (ctl.pwrClr) pwrCnt <= '0;
    else if (ctl.pwrInc) pwrCnt <= pwrCnt + 1'b1;
  end
  assign pwrLast = (pwrCnt == PWR_LAST);

  // Strobe width counter.
  logic [GW-1:0] widCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           widCnt <= '0;
    else if (ctl.widClr) widCnt <= '0;
    else if (ctl.widInc) widCnt <= widCnt + 1'b1;
  end
  assign widLast = (widCnt == WID_LAST);

endmodule

// File: rtl/write_inhibit_guard_control.sv
module write_inhibit_guard_control
  import write_inhibit_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  syncPins_t syncPins,
  input  logic      pwrLast,
  input  logic      widLast,
  output guardCtl_t ctl,
  output logic      wrStart
);

  guardState_e state, nxt;
  logic        writeReq;

  // Write request: select and write low together, output enable high.
  assign writeReq = !syncPins.csN && !syncPins.weN && syncPins.oeN;

  always_comb begin
    nxt = state;
    ctl = '0;
    if (!syncPins.ok) begin
      nxt        = ST_LOCKED;
      ctl.pwrClr = 1'b1;
      ctl.widClr = 1'b1;
    end else begin
      unique case (state)
        ST_LOCKED: begin
          ctl.widClr = 1'b1;
          if (pwrLast) nxt = ST_IDLE;
          else         ctl.pwrInc = 1'b1;
        end
        ST_IDLE, ST_FILTER: begin
          if (!writeReq) begin
            ctl.widClr = 1'b1;
            nxt        = ST_IDLE;
          end else if (widLast) begin
            ctl.widClr = 1'b1;
            nxt        = ST_FIRE;
          end else begin
            ctl.widInc = 1'b1;
            nxt        = ST_FILTER;
          end
        end
        ST_FIRE, ST_HOLD: begin
          ctl.widClr = 1'b1;
          nxt        = writeReq ? ST_HOLD : ST_IDLE;
        end
        default: begin
          ctl.pwrClr = 1'b1;
          ctl.widClr = 1'b1;
          nxt        = ST_LOCKED;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOCKED;
    else       state <= nxt;
  end

  assign wrStart = (state == ST_FIRE);

endmodule

// File: rtl/write_inhibit_guard.sv
module write_inhibit_guard
  import write_inhibit_guard_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int PWR_DELAY_CYC = 250000,
  parameter int GLITCH_CYC    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic csN,
  input  logic oeN,
  input  logic weN,
  output logic wrStart
);

  syncPins_t syncPins;
  guardCtl_t ctl;
  logic      pwrLast;
  logic      widLast;

  write_inhibit_guard_datapath #(
    .SYNC_STAGES  (SYNC_STAGES),
    .PWR_DELAY_CYC(PWR_DELAY_CYC),
    .GLITCH_CYC   (GLITCH_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .supplyOk(supplyOk),
    .csN     (csN),
    .oeN     (oeN),
    .weN     (weN),
    .ctl     (ctl),
    .syncPins(syncPins),
    .pwrLast (pwrLast),
    .widLast (widLast)
  );

  write_inhibit_guard_control u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .syncPins(syncPins),
    .pwrLast (pwrLast),
    .widLast (widLast),
    .ctl     (ctl),
    .wrStart (wrStart)
  );

endmodule

// File: rtl/write_inhibit_guard_chk.sv
module write_inhibit_guard_chk
  import write_inhibit_guard_pkg::*;
#(
  parameter int PWR_DELAY_CYC = 250000,
  parameter int GLITCH_CYC    = 3
) (
  input logic      clk,
  input logic      rstN,
  input syncPins_t syncPins,
  input logic      wrStart
);

  localparam int OW = $clog2(PWR_DELAY_CYC + 2);
  localparam int RW = $clog2(GLITCH_CYC + 2);
  localparam logic [OW-1:0] OK_SAT  = OW'(PWR_DELAY_CYC + 1);
  localparam logic [RW-1:0] REQ_SAT = RW'(GLITCH_CYC + 1);

  logic          reqNow;
  logic [OW-1:0] okRun;
  logic [RW-1:0] reqRun;

  assign reqNow = !syncPins.csN && !syncPins.weN && syncPins.oeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      okRun  <= '0;
      reqRun <= '0;
    end else begin
      okRun  <= !syncPins.ok ? '0 : ((okRun < OK_SAT) ? okRun + 1'b1 : okRun);
      reqRun <= !reqNow ? '0 : ((reqRun < REQ_SAT) ? reqRun + 1'b1 : reqRun);
    end
  end

  AST_LOW_SUPPLY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    !syncPins.ok |=> !wrStart); // R1
  AST_SETTLE_BEFORE_START: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |-> (okRun >= OK_SAT)); // R2
  AST_OE_LOW_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    !syncPins.oeN |=> !wrStart); // R3
  AST_STROBE_HIGH_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (syncPins.csN || syncPins.weN) |=> !wrStart); // R4
  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |-> (reqRun >= RW'(GLITCH_CYC))); // R5
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |=> !wrStart); // R6

endmodule

bind write_inhibit_guard write_inhibit_guard_chk #(
  .PWR_DELAY_CYC(PWR_DELAY_CYC),
  .GLITCH_CYC   (GLITCH_CYC)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .syncPins(syncPins),
  .wrStart (wrStart)
);

// File: tb/tb_write_inhibit_guard.sv
`timescale 1ns/1ps
module tb_write_inhibit_guard;

  localparam int S = 2;
  localparam int P = 20;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b1;
  logic csN = 1'b0;
  logic oeN = 1'b1;
  logic weN = 1'b0;
  logic wrStart;

  int    nCmp = 0;
  int    nBad = 0;
  string curTag = "R8";
  bit    finished = 1'b0;

  always #5 clk = ~clk;

  write_inhibit_guard #(.SYNC_STAGES(S), .PWR_DELAY_CYC(P), .GLITCH_CYC(G)) dut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk),
    .csN(csN), .oeN(oeN), .weN(weN), .wrStart(wrStart)
  );

  // Cycle model from the requirements.
  logic pOk [S];
  logic pCs [S];
  logic pOe [S];
  logic pWe [S];
  int   okRunM = 0;
  int   qRunM = 0;
  logic expFire = 1'b0;

  function automatic logic strobeActive(logic c, logic o, logic w);
    return !c && !w && o;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      okRunM = 0; qRunM = 0; expFire = 1'b0;
      for (int i = 0; i < S; i++) begin
        pOk[i] = 1'b0; pCs[i] = 1'b1; pOe[i] = 1'b1; pWe[i] = 1'b1;
      end
    end else begin
      logic armed, q;
      q = strobeActive(pCs[S-1], pOe[S-1], pWe[S-1]);
      armed = pOk[S-1] && (okRunM >= P);
      qRunM = (armed && q) ? ((qRunM < G + 1) ? qRunM + 1 : qRunM) : 0;
      expFire = (qRunM == G);
      okRunM = pOk[S-1] ? ((okRunM < P + 1) ? okRunM + 1 : okRunM) : 0;
      for (int i = S - 1; i > 0; i--) begin
        pOk[i] = pOk[i-1]; pCs[i] = pCs[i-1]; pOe[i] = pOe[i-1]; pWe[i] = pWe[i-1];
      end
      pOk[0] = supplyOk; pCs[0] = csN; pOe[0] = oeN; pWe[0] = weN;
    end
  end

  task automatic check(string tag, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (!finished) check(curTag, int'(wrStart), int'(expFire));
  end

  task automatic stepN(int n, inout int c);
    repeat (n) begin
      @(negedge clk);
      if (wrStart) c++;
    end
  endtask

  task automatic measLat(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wrStart && n < 200);
  endtask

  task automatic setPins(logic ok, logic c, logic o, logic w);
    supplyOk = ok; csN = c; oeN = o; weN = w;
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int lat, c;
    void'($urandom(32'd20240611));

    // R8: reset state with supply good and strobe active.
    repeat (4) begin
      @(negedge clk);
      check("R8", int'(wrStart), 0);
    end
    rstN = 1'b1;
    curTag = "R2";
    measLat(lat);
    check("R2", lat, S + P + G);
    c = 1;
    stepN(15, c);
    check("R6", c, 1);

    // R7: dip during settling restarts the count.
    curTag = "R7";
    setPins(1'b0, 1'b0, 1'b1, 1'b0);
    c = 0; stepN(1, c);
    setPins(1'b1, 1'b0, 1'b1, 1'b0);
    stepN(P / 2, c);
    setPins(1'b0, 1'b0, 1'b1, 1'b0);
    stepN(1, c);
    setPins(1'b1, 1'b0, 1'b1, 1'b0);
    check("R7", c, 0);
    measLat(lat);
    check("R7", lat, S + P + G);
    setPins(1'b1, 1'b1, 1'b1, 1'b1);
    c = 0; stepN(8, c);

    // R9: strobe-to-pulse latency when armed.
    curTag = "R9";
    setPins(1'b1, 1'b0, 1'b1, 1'b0);
    measLat(lat);
    check("R9", lat, S + G);
    setPins(1'b1, 1'b1, 1'b1, 1'b1);
    c = 0; stepN(8, c);

    // R5: glitch one cycle short, then exactly the width.
    curTag = "R5";
    c = 0;
    setPins(1'b1, 1'b0, 1'b1, 1'b0); stepN(G - 1, c);
    setPins(1'b1, 1'b0, 1'b1, 1'b1); stepN(10, c);
    check("R5", c, 0);
    c = 0;
    setPins(1'b1, 1'b0, 1'b1, 1'b0); stepN(G, c);
    setPins(1'b1, 1'b0, 1'b1, 1'b1); stepN(10, c);
    check("R5", c, 1);

    // R3: output enable low inhibits, release starts.
    curTag = "R3";
    c = 0;
    setPins(1'b1, 1'b0, 1'b0, 1'b0); stepN(20, c);
    check("R3", c, 0);
    setPins(1'b1, 1'b0, 1'b1, 1'b0); stepN(12, c);
    check("R3", c, 1);
    setPins(1'b1, 1'b1, 1'b1, 1'b1); c = 0; stepN(6, c);

    // R4: select high inhibits, late select fall starts.
    curTag = "R4";
    c = 0;
    setPins(1'b1, 1'b1, 1'b1, 1'b0); stepN(20, c);
    check("R4", c, 0);
    setPins(1'b1, 1'b0, 1'b1, 1'b0); stepN(12, c);
    check("R4", c, 1);
    setPins(1'b1, 1'b0, 1'b1, 1'b1); c = 0; stepN(6, c);

    // R1: supply low blocks long strobes.
    curTag = "R1";
    c = 0;
    setPins(1'b0, 1'b1, 1'b1, 1'b1); stepN(3, c);
    for (int k = 0; k < 3; k++) begin
      setPins(1'b0, 1'b0, 1'b1, 1'b0); stepN(10, c);
      setPins(1'b0, 1'b1, 1'b1, 1'b1); stepN(3, c);
    end
    check("R1", c, 0);
    setPins(1'b1, 1'b1, 1'b1, 1'b1); stepN(P + 6, c);

    // Random traffic checked cycle by cycle (R5, R6, R1, R3, R4).
    curTag = "R5";
    for (int b = 0; b < 400; b++) begin
      int kind, len;
      kind = int'($urandom_range(0, 99));
      len  = int'($urandom_range(1, 8));
      c = 0;
      if (kind < 60) begin
        setPins(1'b1, 1'b0, ($urandom_range(0, 9) != 0), 1'b0);
      end else if (kind < 80) begin
        setPins(1'b1, 1'b0, 1'b1, 1'b0);
        len = len + 4;
      end else if (kind < 94) begin
        setPins(1'b1, 1'b1, 1'b1, 1'b1);
      end else begin
        setPins(1'b0, 1'b0, 1'b1, 1'b0);
        len = int'($urandom_range(1, 4));
      end
      stepN(len, c);
      setPins(1'b1, 1'b1, 1'b1, 1'b1);
      stepN(int'($urandom_range(1, 6)), c);
    end

    finishRun();
  end

endmodule